// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Engine

This block is a mode-0 SPI slave that sits in front of a 1024-byte on-chip byte array and behaves like a small serial EEPROM. The chip select, serial clock and serial data input are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. Input bits are captured on a rising SCK edge. The output is shifted after a falling SCK edge. Each transaction starts with an 8-bit opcode. Array commands then take a 16-bit address. All fields travel most significant bit first.

Reads stream bytes from the addressed location and continue while chip select stays low. The address pointer wraps over the whole array. Writes collect up to one page of 16 bytes in a buffer, and the pointer wraps inside that page. A write reaches the array only when chip select rises on a byte boundary, after at least one data byte, and only while the external write-enable latch and the external page permission are both granted. After that rising edge, a parameterised busy counter models the self-timed programming time and copies the buffered bytes into the array. An external protection unit holds the write-enable latch and the protection bits. The block sends it set, clear and status-write strobes, and the unit returns the latch state and a per-page permission.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset, and whenever chip select is high, sdo_en is 0 and busy_o is 0 unless a programming cycle is running.
- R2: Opcode 0x03 followed by a 16-bit address returns the array byte at that address, MSB first. Only the low 10 address bits are used.
- R3: During a read the pointer advances by one after each byte, and it wraps from 0x3FF to 0x000.
- R4: Opcode 0x02, an address and one or more data bytes programs the buffered bytes when chip select rises right after bit 0 of a data byte, with wel_i and page_ok_i both 1. Page locations that received no byte keep their old contents.
- R5: Write data that passes the last byte of a 16-byte page returns to the first byte of the same page, and a later byte overwrites an earlier one.
- R6: A write whose chip select rises in the middle of a byte, or before any data byte, leaves the array unchanged and starts no busy period.
- R7: With wel_i at 0 or page_ok_i at 0 a write changes nothing. chk_page_o presents bits 9..4 of the write address.
- R8: An accepted write keeps busy_o at 1 for exactly BUSY_CYC clock cycles and pulses wel_clr_o once.
- R9: Opcode 0x05 returns the status byte {stat_i[5:0], wel_i, busy_o} repeatedly, and it is allowed while busy.
- R10: While busy, READ, WRITE and opcode 0x01 are ignored. sdo_en stays 0, and the array keeps its contents.
- R11: Opcode 0x06 pulses wel_set_o and opcode 0x04 pulses wel_clr_o, each only if chip select rises after exactly 8 bits.
- R12: Opcode 0x01 followed by one byte pulses sr_wr_o with that byte on sr_data_o, and pulses wel_clr_o, only if chip select rises after exactly 16 bits and wel_i is 1.
- R13: An unknown opcode drives nothing and has no effect until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo (high-impedance when 0) |
| wel_i | input | 1 | Write-enable latch state from the protection unit |
| page_ok_i | input | 1 | Permission to program the page on chk_page_o |
| stat_i | input | 6 | Upper six status bits from the protection unit |
| chk_page_o | output | 6 | Page index of the current write address |
| wel_set_o | output | 1 | Strobe: set the write-enable latch |
| wel_clr_o | output | 1 | Strobe: clear the write-enable latch |
| sr_wr_o | output | 1 | Strobe: write status byte |
| sr_data_o | output | 8 | Status byte to write |
| busy_o | output | 1 | Programming cycle in progress |

## Verification
The assertions assume that SCK edges are separated by several system clocks, so that each synchronised edge reaches the shifter and the decoder before the next edge arrives. They also assume that chip select changes only while SCK is low. The bench holds every SCK half period for eight system clocks. It moves chip select only with SCK low, with a half-period margin on each side. It changes sdi and samples sdo on the falling system clock edge, in the middle of the SCK low phase.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_AH, ST_AL, ST_RD, ST_WR, ST_SR, ST_WSR, ST_SKIP
  } eep_state_t;

  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST_VAL[g];
        q[g] <= RST_VAL[g];
      end else begin
        meta <= d[g];
        q[g] <= meta;
      end
    end
  end
endmodule

// File: rtl/eep_shift.sv
module eep_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_hi,
  input  logic       sck_rise,
  input  logic       sck_fall,
  input  logic       sdi,
  input  logic [7:0] tx_data,
  output logic [7:0] rx_byte,
  output logic       byte_done,
  output logic [2:0] bit_cnt,
  output logic       sdo
);
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;

  always_ff @(posedge clk) begin
    if (rst || cs_hi) begin
      bit_cnt   <= '0;
      byte_done <= 1'b0;
      sdo       <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      if (rst) rx_byte <= '0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[6:0], sdi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_done <= 1'b1;
          rx_byte   <= {rx_sh[6:0], sdi};
        end
      end else if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          sdo   <= tx_data[7];
          tx_sh <= {tx_data[6:0], 1'b0};
        end else begin
          sdo   <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R6
  boundary_chk: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> (bit_cnt == 3'd0));
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
  parameter int PW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr,
  input  logic [PW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int PAGE = 1 << PW;
  logic [DW-1:0]   bytes [PAGE];
  logic [PAGE-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      mask <= '0;
    end else if (wr) begin
      mask[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) bytes[wr_idx] <= wr_data;
  end

  assign rd_data  = bytes[rd_idx];
  assign rd_valid = mask[rd_idx];
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
  import eep_pkg::*;
#(
  parameter int AW = 10,
  parameter int PW = 4,
  parameter int BUSY_CYC = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_en,
  input  logic             wel_i,
  input  logic             page_ok_i,
  input  logic [5:0]       stat_i,
  output logic [AW-PW-1:0] chk_page_o,
  output logic             wel_set_o,
  output logic             wel_clr_o,
  output logic             sr_wr_o,
  output logic [7:0]       sr_data_o,
  output logic             busy_o
);
  localparam int PAGE = 1 << PW;
  localparam int GW   = AW - PW;
  localparam int BW   = $clog2(BUSY_CYC + 1);

  // synchronised pins and edges
  logic [2:0] sq;
  logic cs_q, sck_q, sdi_q, cs_d, sck_d;
  logic cs_rise, sck_rise, sck_fall;

  eep_sync #(.N(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .d({sdi, sck, cs_n}), .q(sq)
  );
  assign cs_q  = sq[0];
  assign sck_q = sq[1];
  assign sdi_q = sq[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      cs_d  <= cs_q;
      sck_d <= sck_q;
    end
  end
  assign cs_rise  = cs_q & ~cs_d;
  assign sck_rise = ~cs_q & sck_q & ~sck_d;
  assign sck_fall = ~cs_q & ~sck_q & sck_d;

  // bit engine
  logic [7:0] rx_byte, tx_data, rdata;
  logic       byte_done;
  logic [2:0] bit_cnt;

  eep_shift u_shift (
    .clk(clk), .rst(rst), .cs_hi(cs_q), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sdi(sdi_q), .tx_data(tx_data), .rx_byte(rx_byte), .byte_done(byte_done),
    .bit_cnt(bit_cnt), .sdo(sdo)
  );

  // command state
  eep_state_t    state;
  logic [7:0]    opc, addr_hi, sr_byte;
  logic [2:0]    nbytes;
  logic [AW-1:0] ptr;
  logic          had_data;
  logic [BW-1:0] bcnt;
  logic [PW:0]   cidx;
  logic [GW-1:0] cpage;
  logic [15:0]   full_addr;
  logic [7:0]    status;

  assign full_addr  = {addr_hi, rx_byte};
  assign busy_o     = (bcnt != '0);
  assign status     = {stat_i, wel_i, busy_o};
  assign chk_page_o = ptr[AW-1:PW];

  always_comb begin
    case (state)
      ST_RD:   tx_data = rdata;
      ST_SR:   tx_data = status;
      default: tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OPC;
      opc       <= '0;
      addr_hi   <= '0;
      sr_byte   <= '0;
      nbytes    <= '0;
      ptr       <= '0;
      had_data  <= 1'b0;
      bcnt      <= '0;
      cidx      <= (PW+1)'(PAGE);
      cpage     <= '0;
      sdo_en    <= 1'b0;
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      sr_wr_o   <= 1'b0;
      sr_data_o <= '0;
    end else begin
      wel_set_o <= 1'b0;
      wel_clr_o <= 1'b0;
      sr_wr_o   <= 1'b0;
      sdo_en    <= ~cs_q && (state == ST_RD || state == ST_SR);
      if (busy_o) begin
        bcnt <= bcnt - 1'b1;
        if (!cidx[PW]) cidx <= cidx + 1'b1;
      end
      if (cs_q) begin
        if (cs_rise && bit_cnt == 3'd0) begin
          if (state == ST_WR && had_data && wel_i && page_ok_i && !busy_o) begin
            bcnt      <= BW'(BUSY_CYC);
            cidx      <= '0;
            cpage     <= ptr[AW-1:PW];
            wel_clr_o <= 1'b1;
          end else if (opc == OP_WREN && nbytes == 3'd1) begin
            wel_set_o <= 1'b1;
          end else if (opc == OP_WRDI && nbytes == 3'd1) begin
            wel_clr_o <= 1'b1;
          end else if (opc == OP_WRSR && nbytes == 3'd2 && state == ST_SKIP
                       && wel_i && !busy_o) begin
            sr_wr_o   <= 1'b1;
            sr_data_o <= sr_byte;
            wel_clr_o <= 1'b1;
          end
        end
        state    <= ST_OPC;
        nbytes   <= '0;
        had_data <= 1'b0;
        opc      <= '0;
      end else if (byte_done) begin
        if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
        case (state)
          ST_OPC: begin
            opc <= rx_byte;
            case (rx_byte)
              OP_READ, OP_WRITE: state <= busy_o ? ST_SKIP : ST_AH;
              OP_RDSR:           state <= ST_SR;
              OP_WRSR:           state <= busy_o ? ST_SKIP : ST_WSR;
              default:           state <= ST_SKIP;
            endcase
          end
          ST_AH: begin
            addr_hi <= rx_byte;
            state   <= ST_AL;
          end
          ST_AL: begin
            ptr   <= full_addr[AW-1:0];
            state <= (opc == OP_READ) ? ST_RD : ST_WR;
          end
          ST_RD: ptr <= ptr + 1'b1;
          ST_WR: begin
            ptr[PW-1:0] <= ptr[PW-1:0] + 1'b1;
            had_data    <= 1'b1;
          end
          ST_WSR: begin
            sr_byte <= rx_byte;
            state   <= ST_SKIP;
          end
          default: state <= state;
        endcase
      end
    end
  end

  // page buffer and array
  logic          pb_clr, pb_wr, pb_valid, arr_we;
  logic [7:0]    pb_data;

  assign pb_clr = byte_done && !cs_q && state == ST_AL && opc == OP_WRITE;
  assign pb_wr  = byte_done && !cs_q && state == ST_WR;
  assign arr_we = busy_o && !cidx[PW] && pb_valid;

  eep_pagebuf #(.PW(PW), .DW(8)) u_pagebuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr(pb_wr), .wr_idx(ptr[PW-1:0]),
    .wr_data(rx_byte), .rd_idx(cidx[PW-1:0]), .rd_data(pb_data), .rd_valid(pb_valid)
  );

  eep_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .we(arr_we), .waddr({cpage, cidx[PW-1:0]}), .wdata(pb_data),
    .raddr(ptr), .rdata(rdata)
  );

  // R1
  sdo_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_q && $past(cs_q)) |-> !sdo_en);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cs_rise));
  // R3
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cs_q && state == ST_RD) |=> (ptr == $past(ptr) + 1'b1));
  // R5
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cs_q && state == ST_WR) |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW])));
  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cs_q && state == ST_OPC && busy_o && rx_byte == OP_READ)
      |=> (state == ST_SKIP));
  // R11
  wel_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(wel_set_o && wel_clr_o));
endmodule

// File: tb/test_eep_spi_slave.sv
module test_eep_spi_slave;
  localparam int CLK_P = 10;
  localparam int HALF  = 8;
  localparam int BUSY  = 2000;

  logic clk = 1'b0;
  logic rst, cs_n, sck, sdi, page_ok;
  logic sdo, sdo_en, wel_set, wel_clr, sr_wr, busy;
  logic [5:0] chk_page;
  logic [7:0] sr_data;
  logic wel;
  logic [5:0] stat = 6'b101011;

  int n_chk = 0, n_err = 0;
  int n_set = 0, n_clr = 0, n_sr = 0, busy_len = 0;
  logic [7:0] rbuf [32];

  always #(CLK_P/2) clk = ~clk;

  eep_spi_slave #(.AW(10), .PW(4), .BUSY_CYC(BUSY)) i_eep_spi_slave (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en),
    .wel_i(wel), .page_ok_i(page_ok), .stat_i(stat), .chk_page_o(chk_page),
    .wel_set_o(wel_set), .wel_clr_o(wel_clr), .sr_wr_o(sr_wr), .sr_data_o(sr_data),
    .busy_o(busy)
  );

  // protection unit model
  always @(posedge clk) begin
    if (rst) wel <= 1'b0;
    else if (wel_set) wel <= 1'b1;
    else if (wel_clr) wel <= 1'b0;
    if (wel_set) n_set++;
    if (wel_clr) n_clr++;
    if (sr_wr) n_sr++;
    if (busy) busy_len++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sdi = tx[i];
      wait_cyc(HALF);
      rx[i] = sdo;
      sck = 1'b1;
      wait_cyc(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    bits(tx, 8, rx);
  endtask

  task automatic sel;
    cs_n = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic desel;
    wait_cyc(HALF);
    cs_n = 1'b1;
    wait_cyc(2*HALF);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel(); xfer(op, r); desel();
  endtask

  task automatic head(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] r;
    xfer(op, r); xfer(a[15:8], r); xfer(a[7:0], r);
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] base);
    logic [7:0] r;
    sel(); head(8'h02, a);
    for (int i = 0; i < n; i++) xfer(base + 8'(i), r);
    desel();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] r;
    sel(); head(8'h03, a);
    for (int i = 0; i < n; i++) begin xfer(8'h00, r); rbuf[i] = r; end
    desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel(); xfer(8'h05, r); xfer(8'h00, s); desel();
  endtask

  task automatic wait_idle;
    wait_cyc(4);
    while (busy) wait_cyc(1);
    wait_cyc(2);
  endtask

  // stimulus table: {16-bit address, data byte}
  localparam logic [23:0] VEC [6] = '{
    24'h0000_A5, 24'h0001_3C, 24'hFFFF_C3, 24'h0212_5A, 24'h7C40_81, 24'h03F0_E1
  };

  initial begin
    logic [7:0] r, s;
    int a0, b0;
    cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; page_ok = 1'b1; rst = 1'b1;
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(5);
    chk("R1 sdo_en after reset", int'(sdo_en), 0);
    chk("R1 busy after reset", int'(busy), 0);

    for (int k = 0; k < 6; k++) begin
      op1(8'h06);
      busy_len = 0;
      a0 = n_clr;
      wr(VEC[k][23:8], 1, VEC[k][7:0]);
      wait_idle();
      chk("R8 busy length", busy_len, BUSY);
      chk("R8 wel_clr pulse on commit", n_clr - a0, 1);
      chk("R4 latch cleared", int'(wel), 0);
      rd(VEC[k][23:8], 1);
      chk("R4 table readback", int'(rbuf[0]), int'(VEC[k][7:0]));
    end

    // R2: upper address bits ignored
    rd(16'hFC00, 1);
    chk("R2 upper bits ignored", int'(rbuf[0]), 8'hA5);

    // R3: sequential wrap across array end
    rd(16'h03FF, 3);
    chk("R3 byte at 0x3FF", int'(rbuf[0]), 8'hC3);
    chk("R3 wrap to 0x000", int'(rbuf[1]), 8'hA5);
    chk("R3 then 0x001", int'(rbuf[2]), 8'h3C);

    // R4: untouched page bytes keep contents
    op1(8'h06);
    wr(16'h0041, 1, 8'h99);
    wait_idle();
    rd(16'h0040, 2);
    chk("R4 unwritten byte kept", int'(rbuf[0]), 8'h81);
    chk("R4 written byte", int'(rbuf[1]), 8'h99);

    // R5: page wrap with overwrite
    op1(8'h06);
    wr(16'h0100, 17, 8'h10);
    wait_idle();
    rd(16'h0100, 16);
    chk("R5 offset 0 overwritten", int'(rbuf[0]), 8'h20);
    chk("R5 offset 1", int'(rbuf[1]), 8'h11);
    chk("R5 offset 15", int'(rbuf[15]), 8'h1F);

    // R6: mid-byte abort and no data byte
    op1(8'h06);
    sel(); head(8'h02, 16'h0212); bits(8'h00, 4, r); desel();
    wait_cyc(4);
    chk("R6 no busy after abort", int'(busy), 0);
    sel(); head(8'h02, 16'h0212); desel();
    wait_cyc(4);
    chk("R6 no busy without data", int'(busy), 0);
    rd(16'h0212, 1);
    chk("R6 array unchanged", int'(rbuf[0]), 8'h5A);
    a0 = n_clr;
    op1(8'h04);
    chk("R11 WRDI clears", n_clr - a0, 1);
    chk("R11 latch low", int'(wel), 0);

    // R7: permission denied
    wr(16'h0212, 1, 8'h11);
    wait_cyc(4);
    chk("R7 no busy without latch", int'(busy), 0);
    op1(8'h06);
    page_ok = 1'b0;
    sel(); head(8'h02, 16'h0212);
    wait_cyc(4);
    chk("R7 page index", int'(chk_page), 6'h21);
    xfer(8'h11, r); desel();
    wait_cyc(4);
    chk("R7 no busy when page refused", int'(busy), 0);
    page_ok = 1'b1;
    rd(16'h0212, 1);
    chk("R7 array unchanged", int'(rbuf[0]), 8'h5A);

    // R9 and R10: operations during busy (latch still set here)
    wr(16'h0300, 1, 8'h42);
    wait_cyc(4);
    rdsr(s);
    chk("R9 status while busy", int'(s), 8'hAD);
    sel(); head(8'h03, 16'h0300);
    wait_cyc(4);
    chk("R10 read ignored while busy", int'(sdo_en), 0);
    desel();
    op1(8'h06);
    wr(16'h0300, 1, 8'h77);
    chk("R10 still busy", int'(busy), 1);
    wait_idle();
    rd(16'h0300, 1);
    chk("R10 write ignored while busy", int'(rbuf[0]), 8'h42);
    rdsr(s);
    chk("R9 status idle with latch", int'(s), 8'hAE);
    op1(8'h04);

    // R11: WREN needs exactly 8 bits
    a0 = n_set;
    sel(); xfer(8'h06, r); bits(8'h00, 1, r); desel();
    chk("R11 WREN with 9 bits ignored", n_set - a0, 0);
    op1(8'h06);
    chk("R11 WREN sets", n_set - a0, 1);
    chk("R11 latch high", int'(wel), 1);

    // R12: status write
    b0 = n_sr;
    sel(); xfer(8'h01, r); xfer(8'h8C, r); desel();
    chk("R12 sr_wr pulse", n_sr - b0, 1);
    chk("R12 sr_data", int'(sr_data), 8'h8C);
    chk("R12 latch cleared", int'(wel), 0);
    sel(); xfer(8'h01, r); xfer(8'h33, r); desel();
    chk("R12 no pulse without latch", n_sr - b0, 1);

    // R13: unknown opcode
    a0 = n_set + n_clr + n_sr;
    sel(); xfer(8'hAB, r); xfer(8'h00, r); xfer(8'h00, r);
    wait_cyc(4);
    chk("R13 no drive on unknown opcode", int'(sdo_en), 0);
    xfer(8'h55, r); desel();
    wait_cyc(4);
    chk("R13 no strobes", n_set + n_clr + n_sr - a0, 0);
    chk("R13 no busy", int'(busy), 0);
    rd(16'h0000, 1);
    chk("R13 array unchanged", int'(rbuf[0]), 8'hA5);
    chk("R1 sdo_en idle at end", int'(sdo_en), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule